// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block decides which operating mode a CAN protocol controller is in: Sleep, Initialization or Normal. Software drives three request levels: a sleep request, an initialization request and an automatic-wakeup enable. The protocol engine drives bus-activity levels (transmitting, receiving, frame in progress), a sampled Rx bit with a one-cycle bit-time strobe, and a start-of-frame pulse. The block holds back each mode change until the current frame has finished. It enters Normal operation only after it has seen eleven recessive bits in a row, which synchronises it to the bus.

The result appears in a byte-wide status word. The word holds the two mode acknowledges, the wakeup and error interrupt flags, and live transmitter and receiver indications. Both interrupt flags are cleared by writing 1 to them. A status-change interrupt line combines the two flags with their enables.

When automatic wakeup is enabled, the block can drop the sleep request by hardware. It does this in two cases: a start of frame wakes it from Sleep, or a sleep request arrives while the bus is busy and is refused. In both cases the block pulses `sleep_req_clr` so that the register that holds the request can clear it. Until software lowers the request, the block treats it as absent.

Top module: `can_mode_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, the block is in Sleep mode and `status` reads 0x02.
- R2: `status` bit 0 is the init acknowledge, bit 1 the sleep acknowledge, bit 2 the error flag, bit 3 the wakeup flag, bit 4 follows `tx_active` and bit 5 follows `rx_active` in the same cycle. Bits 7:6 always read 0.
- R3: While `init_req` is high and any of `tx_active`, `rx_active` or `frame_busy` is high, the init acknowledge does not rise. One cycle after all three are low, the block enters Initialization and the init acknowledge is 1.
- R4: After `init_req` falls, the init acknowledge stays 1 until 11 consecutive recessive bits have been sampled. One cycle after the eleventh, the block is in Normal mode and `status` bit 0 is 0.
- R5: A dominant bit (`rx_bit`=0) sampled on a `bit_tick` restarts the recessive run from zero. `rx_bit` is only counted in cycles where `bit_tick` is high.
- R6: With `auto_wake_en`=0, a sleep request from Normal waits until `tx_active`, `rx_active` and `frame_busy` are all low. One cycle later the block is in Sleep and `status` bit 1 is 1.
- R7: With `auto_wake_en`=1, a sleep request made while the bus is busy is refused. The block stays out of Sleep, the sleep acknowledge stays 0, the wakeup flag is set and `sleep_req_clr` pulses.
- R8: With `auto_wake_en`=1, a `sof_det` pulse in Sleep pulses `sleep_req_clr` and leaves Sleep. The sleep acknowledge stays 1 until the 11-recessive-bit synchronisation completes, and then the block is in Normal mode.
- R9: A `sof_det` pulse in Sleep sets the wakeup flag (bit 3) whatever the value of `auto_wake_en`. Writing 1 to bit 3 clears it. Writing 0 to bit 3 leaves it unchanged.
- R10: The error flag (bit 2) is set when an `err_hit` bit pulses and the matching `err_hit_en` bit is 1. A pulse on a source whose enable is 0 does not set it. Writing 1 to bit 2 clears it.
- R11: `irq` is 1 exactly when (wakeup flag AND `wake_ie`) OR (error flag AND `err_ie`).
- R12: With both `init_req` and `sleep_req` high, Initialization is entered. Lowering `init_req` while `sleep_req` stays high enters Sleep. Lowering `sleep_req` while asleep returns the block to Normal through the 11-recessive-bit synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Software sleep request level |
| init_req | input | 1 | Software initialization request level |
| auto_wake_en | input | 1 | Automatic wakeup enable |
| tx_active | input | 1 | Controller is currently transmitting |
| rx_active | input | 1 | Controller is currently receiving |
| frame_busy | input | 1 | A frame is in progress on the bus |
| rx_bit | input | 1 | Sampled Rx level, 1 = recessive |
| bit_tick | input | 1 | One-cycle bit-time strobe qualifying `rx_bit` |
| sof_det | input | 1 | Start-of-frame detected pulse |
| err_hit | input | NUM_ERR_SRC | Error-status bits raised this cycle |
| err_hit_en | input | NUM_ERR_SRC | Per-source error interrupt enables |
| wake_ie | input | 1 | Wakeup flag interrupt enable |
| err_ie | input | 1 | Error flag interrupt enable |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 8 | Status write data, 1 clears a flag |
| status | output | 8 | Status word |
| irq | output | 1 | Status-change interrupt |
| sleep_req_clr | output | 1 | Pulse asking the request register to drop the sleep request |

## Verification
Every cycle, the assertions check the following. The two acknowledges are never set together. The reserved bits stay 0. Initialization is entered only with an idle bus, and Sleep is entered from an active mode only with an idle bus. Normal mode is reached only after a completed recessive run. The run count stays in range and a dominant bit restarts it. A refused sleep request never lands in Sleep. A write of 1 clears a flag, and `irq` never rises without a set flag. Some behaviour can only be shown by the bench's scenarios: the exact cycle of each acknowledge change, the ten-versus-eleven-bit boundary, a dominant bit restarting a partial run, the handling of the pending request and `sleep_req_clr` on wakeup and refusal, and the init-over-sleep ordering.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_SYNC   = 2'd2,
    MODE_NORMAL = 2'd3
  } mode_e;

  localparam int STB_INIT_ACK  = 0;
  localparam int STB_SLEEP_ACK = 1;
  localparam int STB_ERR_FLAG  = 2;
  localparam int STB_WAKE_FLAG = 3;
  localparam int STB_TX        = 4;
  localparam int STB_RX        = 5;

  // Next value of a recessive-run counter on a bit strobe (saturating).
  function automatic int run_next(input int cur, input logic bit_val, input int limit);
    if (!bit_val) return 0;
    if (cur >= limit) return limit;
    return cur + 1;
  endfunction

  // Write-one-to-clear flag update; a set event wins over a clear.
  function automatic logic flag_next(input logic cur, input logic set_ev, input logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction

endpackage

// File: rtl/can_recessive_sync.sv
module can_recessive_sync #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_tick,
  input  logic rx_bit,
  output logic run_done
);
  import can_mode_pkg::*;

  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] run_cnt;
  logic          dom_restart;
  logic          rec_step;

  assign dom_restart = active & bit_tick & ~rx_bit;
  assign rec_step    = active & bit_tick & rx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!active) begin
      run_cnt <= '0;
    end else if (bit_tick) begin
      run_cnt <= CW'(run_next(int'(run_cnt), rx_bit, RUN_LEN));
    end
  end

  assign run_done = active & (int'(run_cnt) == RUN_LEN);

  // R5: count never leaves its range
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_cnt) <= RUN_LEN);

  // R5: one dominant bit restarts the run
  assert_dominant_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dom_restart |=> run_cnt == '0);

  // R5: without a strobe the count holds
  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bit_tick && !rec_step && $past(active)) |=> $stable(run_cnt) || !active);

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic init_req,
  input  logic auto_wake_en,
  input  logic bus_busy,
  input  logic sof_det,
  input  logic sync_done,
  output logic sync_active,
  output logic init_ack,
  output logic sleep_ack,
  output logic wake_evt,
  output logic kill_evt
);
  import can_mode_pkg::*;

  mode_e mode_q, mode_d;
  logic  from_sleep_q, from_sleep_d;
  logic  kill_q;
  logic  sleep_eff;
  logic  refuse_cond;

  assign sleep_eff = sleep_req & ~kill_q;

  // Active-mode sleep refusal condition (auto wakeup on, bus busy)
  assign refuse_cond = (mode_q == MODE_SYNC || mode_q == MODE_NORMAL) &&
                       !init_req && sleep_eff && auto_wake_en && bus_busy;

  always_comb begin
    mode_d       = mode_q;
    from_sleep_d = from_sleep_q;
    wake_evt     = 1'b0;
    kill_evt     = 1'b0;
    unique case (mode_q)
      MODE_SLEEP: begin
        if (init_req) begin
          if (!bus_busy) mode_d = MODE_INIT;
        end else if (sof_det) begin
          wake_evt = 1'b1;
          if (auto_wake_en && sleep_eff) begin
            kill_evt     = 1'b1;
            mode_d       = MODE_SYNC;
            from_sleep_d = 1'b1;
          end
        end else if (!sleep_eff) begin
          mode_d       = MODE_SYNC;
          from_sleep_d = 1'b1;
        end
      end
      MODE_INIT: begin
        if (!init_req) begin
          if (sleep_eff) begin
            mode_d = MODE_SLEEP;
          end else begin
            mode_d       = MODE_SYNC;
            from_sleep_d = 1'b0;
          end
        end
      end
      default: begin
        if (init_req) begin
          if (!bus_busy) mode_d = MODE_INIT;
        end else if (sleep_eff) begin
          if (auto_wake_en && bus_busy) begin
            kill_evt = 1'b1;
            wake_evt = 1'b1;
          end else if (!bus_busy) begin
            mode_d = MODE_SLEEP;
          end
        end else if (mode_q == MODE_SYNC && sync_done) begin
          mode_d = MODE_NORMAL;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MODE_SLEEP;
      from_sleep_q <= 1'b1;
      kill_q       <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      from_sleep_q <= from_sleep_d;
      if (kill_evt)       kill_q <= 1'b1;
      else if (!sleep_req) kill_q <= 1'b0;
    end
  end

  assign sync_active = (mode_q == MODE_SYNC);
  assign init_ack    = (mode_q == MODE_INIT)  || (sync_active && !from_sleep_q);
  assign sleep_ack   = (mode_q == MODE_SLEEP) || (sync_active &&  from_sleep_q);

  // R2: the two acknowledges are never set together
  assert_ack_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_ack, sleep_ack}));

  // R3: Initialization is only entered with an idle bus
  assert_init_entry_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_INIT && $past(mode_q) != MODE_INIT) |-> $past(!bus_busy));

  // R4: Normal is only reached after a complete recessive run
  assert_sync_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NORMAL && $past(mode_q) == MODE_SYNC) |-> $past(sync_done));

  // R6: Sleep from an active mode only with an idle bus
  assert_sleep_entry_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLEEP && ($past(mode_q) == MODE_NORMAL || $past(mode_q) == MODE_SYNC))
      |-> $past(!bus_busy));

  // R7: a refused request never lands in Sleep
  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_cond |=> (mode_q != MODE_SLEEP) && kill_q);

endmodule

// File: rtl/can_status_flags.sv
module can_status_flags #(
  parameter int NUM_ERR_SRC = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wake_evt,
  input  logic [NUM_ERR_SRC-1:0] err_hit,
  input  logic [NUM_ERR_SRC-1:0] err_hit_en,
  input  logic                   wake_ie,
  input  logic                   err_ie,
  input  logic                   st_wr,
  input  logic [7:0]             st_wdata,
  output logic                   wake_flag,
  output logic                   err_flag,
  output logic                   irq
);
  import can_mode_pkg::*;

  logic                   err_evt;
  logic                   wake_clr;
  logic                   err_clr;
  logic [NUM_ERR_SRC-1:0] err_qual;

  for (genvar g = 0; g < NUM_ERR_SRC; g++) begin : g_err_qual
    assign err_qual[g] = err_hit[g] & err_hit_en[g];
  end

  assign err_evt  = |err_qual;
  assign wake_clr = st_wr & st_wdata[STB_WAKE_FLAG];
  assign err_clr  = st_wr & st_wdata[STB_ERR_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      wake_flag <= flag_next(wake_flag, wake_evt, wake_clr);
      err_flag  <= flag_next(err_flag, err_evt, err_clr);
    end
  end

  assign irq = (wake_flag & wake_ie) | (err_flag & err_ie);

  // R9: write 1 with no new event clears the wakeup flag
  assert_wake_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clr && !wake_evt) |=> !wake_flag);

  // R9: writing 0 never clears the wakeup flag
  assert_wake_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !wake_clr) |=> wake_flag);

  // R10: write 1 with no new event clears the error flag
  assert_err_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_evt) |=> !err_flag);

  // R11: no interrupt without a flag
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (wake_flag || err_flag));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
  parameter int NUM_ERR_SRC = 6,
  parameter int SYNC_BITS   = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sleep_req,
  input  logic                   init_req,
  input  logic                   auto_wake_en,
  input  logic                   tx_active,
  input  logic                   rx_active,
  input  logic                   frame_busy,
  input  logic                   rx_bit,
  input  logic                   bit_tick,
  input  logic                   sof_det,
  input  logic [NUM_ERR_SRC-1:0] err_hit,
  input  logic [NUM_ERR_SRC-1:0] err_hit_en,
  input  logic                   wake_ie,
  input  logic                   err_ie,
  input  logic                   st_wr,
  input  logic [7:0]             st_wdata,
  output logic [7:0]             status,
  output logic                   irq,
  output logic                   sleep_req_clr
);
  import can_mode_pkg::*;

  logic bus_busy;
  logic sync_active;
  logic sync_done;
  logic init_ack;
  logic sleep_ack;
  logic wake_evt;
  logic kill_evt;
  logic wake_flag;
  logic err_flag;

  assign bus_busy = tx_active | rx_active | frame_busy;

  can_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .init_req     (init_req),
    .auto_wake_en (auto_wake_en),
    .bus_busy     (bus_busy),
    .sof_det      (sof_det),
    .sync_done    (sync_done),
    .sync_active  (sync_active),
    .init_ack     (init_ack),
    .sleep_ack    (sleep_ack),
    .wake_evt     (wake_evt),
    .kill_evt     (kill_evt)
  );

  can_recessive_sync #(.RUN_LEN(SYNC_BITS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (sync_active),
    .bit_tick (bit_tick),
    .rx_bit   (rx_bit),
    .run_done (sync_done)
  );

  can_status_flags #(.NUM_ERR_SRC(NUM_ERR_SRC)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_evt   (wake_evt),
    .err_hit    (err_hit),
    .err_hit_en (err_hit_en),
    .wake_ie    (wake_ie),
    .err_ie     (err_ie),
    .st_wr      (st_wr),
    .st_wdata   (st_wdata),
    .wake_flag  (wake_flag),
    .err_flag   (err_flag),
    .irq        (irq)
  );

  always_comb begin
    status                = '0;
    status[STB_INIT_ACK]  = init_ack;
    status[STB_SLEEP_ACK] = sleep_ack;
    status[STB_ERR_FLAG]  = err_flag;
    status[STB_WAKE_FLAG] = wake_flag;
    status[STB_TX]        = tx_active;
    status[STB_RX]        = rx_active;
  end

  assign sleep_req_clr = kill_evt;

  // R2: reserved bits stay zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:6] == 2'b00);

  // R8: hardware drop of the request only with auto wakeup on
  assert_clr_needs_awake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req_clr |-> (auto_wake_en && sleep_req));

endmodule

// File: tb/tb_can_mode_seq.sv
`timescale 1ns/1ps
module tb_can_mode_seq;
  localparam int NE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b1, init_req = 1'b0, auto_wake_en = 1'b0;
  logic tx_active = 1'b0, rx_active = 1'b0, frame_busy = 1'b0;
  logic rx_bit = 1'b1, bit_tick = 1'b0, sof_det = 1'b0;
  logic [NE-1:0] err_hit = '0, err_hit_en = '0;
  logic wake_ie = 1'b0, err_ie = 1'b0, st_wr = 1'b0;
  logic [7:0] st_wdata = '0;
  logic [7:0] status;
  logic irq, sleep_req_clr;

  int n_checks = 0;
  int n_fail = 0;
  logic clr_seen = 1'b0;

  always #2.5 clk = ~clk;

  can_mode_seq #(.NUM_ERR_SRC(NE), .SYNC_BITS(11)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .init_req(init_req),
    .auto_wake_en(auto_wake_en), .tx_active(tx_active), .rx_active(rx_active),
    .frame_busy(frame_busy), .rx_bit(rx_bit), .bit_tick(bit_tick), .sof_det(sof_det),
    .err_hit(err_hit), .err_hit_en(err_hit_en), .wake_ie(wake_ie), .err_ie(err_ie),
    .st_wr(st_wr), .st_wdata(st_wdata), .status(status), .irq(irq),
    .sleep_req_clr(sleep_req_clr)
  );

  always @(posedge clk) if (sleep_req_clr) clr_seen <= 1'b1;

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic send_bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      rx_bit = v; bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      @(negedge clk);
    end
    rx_bit = 1'b1;
  endtask

  task automatic write_status(input logic [7:0] d);
    st_wr = 1'b1; st_wdata = d;
    @(negedge clk);
    st_wr = 1'b0; st_wdata = '0;
    @(negedge clk);
  endtask

  task automatic t_reset_r1;
    cyc(3);
    chk8(status, 8'h02, "R1 status during reset");
    rst_n = 1'b1;
    cyc(1);
    chk8(status, 8'h02, "R1 status after reset");
  endtask

  task automatic t_wake_by_clear_r12;
    sleep_req = 1'b0;
    cyc(2);
    send_bits(10, 1'b1);
    cyc(1);
    chk8(status, 8'h02, "R12 sleep ack held after 10 recessive");
    send_bits(1, 1'b1);
    cyc(1);
    chk8(status, 8'h00, "R12 normal after 11 recessive");
  endtask

  task automatic t_init_deferred_r3;
    tx_active = 1'b1; init_req = 1'b1;
    cyc(5);
    chk8(status, 8'h10, "R3 init deferred while transmitting, R2 tx bit");
    tx_active = 1'b0; rx_active = 1'b1;
    cyc(3);
    chk8(status, 8'h20, "R3 init deferred while receiving, R2 rx bit");
    rx_active = 1'b0; frame_busy = 1'b1;
    cyc(3);
    chk8(status, 8'h00, "R3 init deferred while frame busy");
    frame_busy = 1'b0;
    cyc(1);
    chk8(status, 8'h01, "R3 init ack one cycle after idle");
  endtask

  task automatic t_sync_r4_r5;
    init_req = 1'b0;
    cyc(2);
    chk8(status, 8'h01, "R4 init ack held after request drop");
    send_bits(6, 1'b1);
    send_bits(1, 1'b0);
    send_bits(10, 1'b1);
    cyc(1);
    chk8(status, 8'h01, "R5 dominant restarted run");
    rx_bit = 1'b0;
    cyc(30);
    rx_bit = 1'b1;
    chk8(status, 8'h01, "R5 no count without strobe");
    send_bits(1, 1'b1);
    cyc(1);
    chk8(status, 8'h00, "R4 normal after 11 in a row");
  endtask

  task automatic t_sleep_noawake_r6_r9;
    auto_wake_en = 1'b0;
    rx_active = 1'b1; sleep_req = 1'b1;
    cyc(4);
    chk8(status, 8'h20, "R6 sleep deferred while receiving");
    rx_active = 1'b0;
    cyc(1);
    chk8(status, 8'h02, "R6 sleep entered after idle");
    sof_det = 1'b1; cyc(1); sof_det = 1'b0;
    chk8(status, 8'h0A, "R9 sof in sleep sets wakeup flag");
    chk1(irq, 1'b0, "R11 irq low with wake_ie off");
    wake_ie = 1'b1;
    cyc(1);
    chk1(irq, 1'b1, "R11 irq with wakeup flag and enable");
    write_status(8'hF7);
    chk8(status, 8'h0A, "R9 writing 0 to wakeup flag keeps it");
    write_status(8'h08);
    chk8(status, 8'h02, "R9 write 1 clears wakeup flag");
    chk1(irq, 1'b0, "R11 irq drops with flag");
    sleep_req = 1'b0;
    cyc(2);
    send_bits(11, 1'b1);
    cyc(1);
    chk8(status, 8'h00, "R12 back to normal from sleep");
  endtask

  task automatic t_refuse_r7;
    auto_wake_en = 1'b1; frame_busy = 1'b1; clr_seen = 1'b0;
    sleep_req = 1'b1;
    cyc(1);
    chk1(clr_seen, 1'b1, "R7 sleep_req_clr pulsed on refusal");
    chk8(status, 8'h08, "R7 refused: no sleep ack, wakeup flag set");
    frame_busy = 1'b0;
    cyc(3);
    chk8(status, 8'h08, "R7 refused request stays dropped");
    sleep_req = 1'b0;
    write_status(8'h08);
    chk8(status, 8'h00, "R7 wakeup flag cleared");
  endtask

  task automatic t_autowake_r8;
    auto_wake_en = 1'b1; sleep_req = 1'b1;
    cyc(2);
    chk8(status, 8'h02, "R8 idle sleep entry with auto wakeup");
    clr_seen = 1'b0;
    sof_det = 1'b1; cyc(1); sof_det = 1'b0;
    chk1(clr_seen, 1'b1, "R8 sleep_req_clr pulsed on sof");
    chk8(status, 8'h0A, "R8 sleep ack held during sync, wakeup flag set");
    sleep_req = 1'b0;
    send_bits(11, 1'b1);
    cyc(1);
    chk8(status, 8'h08, "R8 normal after wake sync");
    write_status(8'h08);
    wake_ie = 1'b0;
  endtask

  task automatic t_error_r10;
    err_hit_en = 6'b000100;
    err_hit = 6'b000010; cyc(1); err_hit = '0;
    cyc(1);
    chk8(status, 8'h00, "R10 disabled source ignored");
    err_hit = 6'b000100; cyc(1); err_hit = '0;
    chk8(status, 8'h04, "R10 enabled source sets error flag");
    chk1(irq, 1'b0, "R11 irq low with err_ie off");
    err_ie = 1'b1;
    cyc(1);
    chk1(irq, 1'b1, "R11 irq with error flag and enable");
    write_status(8'h04);
    chk8(status, 8'h00, "R10 write 1 clears error flag");
    err_ie = 1'b0;
  endtask

  task automatic t_priority_r12;
    auto_wake_en = 1'b0;
    init_req = 1'b1; sleep_req = 1'b1;
    cyc(1);
    chk8(status, 8'h01, "R12 init wins over sleep");
    init_req = 1'b0;
    cyc(1);
    chk8(status, 8'h02, "R12 init drop with sleep pending enters sleep");
    sleep_req = 1'b0;
    cyc(2);
    send_bits(11, 1'b1);
    cyc(1);
    chk8(status, 8'h00, "R12 normal after sleep exit sync");
  endtask

  initial begin
    @(negedge clk);
    t_reset_r1();
    t_wake_by_clear_r12();
    t_init_deferred_r3();
    t_sync_r4_r5();
    t_sleep_noawake_r6_r9();
    t_refuse_r7();
    t_autowake_r8();
    t_error_r10();
    t_priority_r12();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule